// File: doc/BRIEF.md
# Conditional Branch and Loop Unit

This unit decides whether a control-transfer instruction is taken and produces the address that fetch should use next. Decode supplies the address of the sequential successor, a branch-kind code, and a relative displacement. The displacement is either a sign-extended single byte or a full 32-bit word. The unit also receives the loop counter value and a 32-bit indirect target, for example an entry read from a jump table.

A small flag register holds carry, zero, sign and overflow. A compare strobe loads it from the subtraction destination minus source, and no result is written anywhere. An arithmetic-result strobe loads it with flags produced by the execution unit. Conditional kinds test the stored flags.

The loop kind is fused. It reports the counter minus one together with a write-enable, and it is taken while that decremented value is nonzero. The decision path is combinational, so a branch sees the flags as they stood before the current clock edge.

Top module: `branch_loop_unit`

## Requirements
- R1: After reset the flag output `cc` is 4'b0000. Its bit order is {overflow, sign, zero, carry}, from bit 3 down to bit 0.
- R2: Kind codes are 0 none, 1 relative jump, 2 indirect jump, 3 jump-if-greater, 4 jump-if-zero, 5 jump-if-sign and 6 loop. Codes 7 to 15 behave as none.
- R3: A relative target is `next_pc` plus the displacement. With `off_wide`=0 only `rel_off[7:0]` is used, sign-extended, so the span is −128..+127. With `off_wide`=1 all 32 bits are used.
- R4: Kind 2 is always taken, and its target is `ind_tgt`.
- R5: Kind 1 is always taken.
- R6: Jump-if-greater is taken exactly when zero is clear and sign equals overflow.
- R7: Jump-if-zero is taken when the zero flag is set. Jump-if-sign is taken when the sign flag is set.
- R8: With `cmp_en`=1, the flags after the next edge follow `cmp_dst − cmp_src` modulo 2^32:
  - carry is the unsigned borrow;
  - zero is set for a zero difference;
  - sign is the difference MSB;
  - overflow is the signed overflow.
- R9: With `res_en`=1 and `cmp_en`=0, the flags after the next edge equal `res_cc`. Compare wins if both strobes are high.
- R10: With neither strobe high, the flags hold. A loop operation leaves them unchanged.
- R11: For kind 6, `cnt_we`=1 and `cnt_out`=`cnt_in`−1 modulo 2^32, and the branch is taken when that value is nonzero. For every other kind, `cnt_we`=0 and `cnt_out`=`cnt_in`.
- R12: When not taken, `tgt_addr` equals `next_pc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| next_pc | input | 32 | Address of the following instruction |
| br_kind | input | 4 | Branch kind code |
| rel_off | input | 32 | Relative displacement |
| off_wide | input | 1 | 1 selects the 32-bit displacement, 0 the byte |
| ind_tgt | input | 32 | Indirect target value |
| cnt_in | input | 32 | Current loop counter |
| cmp_en | input | 1 | Compare strobe |
| cmp_dst | input | 32 | Compare destination operand |
| cmp_src | input | 32 | Compare source operand |
| res_en | input | 1 | Arithmetic-result flag strobe |
| res_cc | input | 4 | Flags from an arithmetic result |
| taken | output | 1 | Branch is taken |
| tgt_addr | output | 32 | Next fetch address |
| cnt_out | output | 32 | Updated counter value |
| cnt_we | output | 1 | Counter write-enable |
| cc | output | 4 | Stored flags {OF,SF,ZF,CF} |

## Verification
The properties assume that every input is driven to a known level on each sampled edge from reset onward. They also assume the compare operands are stable across the edge that captures them, because the flag checks compare against the previous cycle's operands. The bench drives all inputs to defined values from time zero. It changes them only at the falling edge and releases each strobe after a single rising edge, so every captured operand pair is unambiguous.

// File: rtl/bl_pkg.sv
package bl_pkg;
    typedef enum logic [3:0] {
        BK_NONE = 4'd0,
        BK_JMP  = 4'd1,
        BK_JIND = 4'd2,
        BK_JG   = 4'd3,
        BK_JZ   = 4'd4,
        BK_JS   = 4'd5,
        BK_LOOP = 4'd6
    } br_kind_e;

    typedef struct packed {
        logic ovf;
        logic sgn;
        logic zro;
        logic cry;
    } cc_t;
endpackage

// File: rtl/bl_flag_unit.sv
module bl_flag_unit
    import bl_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmp_en,
    input  logic [DW-1:0] cmp_dst,
    input  logic [DW-1:0] cmp_src,
    input  logic          res_en,
    input  cc_t           res_cc,
    output cc_t           cc_q_o
);
    typedef struct packed {
        cc_t cc;
    } st_t;

    st_t st_d, st_q;
    logic [DW:0] diff_ext;
    cc_t cmp_cc;

    always_comb begin
        diff_ext   = {1'b0, cmp_dst} - {1'b0, cmp_src};
        cmp_cc.cry = diff_ext[DW];
        cmp_cc.zro = (diff_ext[DW-1:0] == '0);
        cmp_cc.sgn = diff_ext[DW-1];
        cmp_cc.ovf = (cmp_dst[DW-1] != cmp_src[DW-1]) &&
                     (diff_ext[DW-1] != cmp_dst[DW-1]);

        st_d = st_q;
        if (cmp_en)      st_d.cc = cmp_cc;
        else if (res_en) st_d.cc = res_cc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cc_q_o = st_q.cc;

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_en && !res_en) |=> $stable(cc_q_o)); // R10
    AST_CMP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_en |=> (cc_q_o.zro == ($past(cmp_dst) == $past(cmp_src)))); // R8
    AST_CMP_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_en |=> (cc_q_o.cry == ($past(cmp_dst) < $past(cmp_src)))); // R8
    AST_RES_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (res_en && !cmp_en) |=> (cc_q_o == $past(res_cc))); // R9
endmodule

// File: rtl/bl_cond_eval.sv
module bl_cond_eval
    import bl_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic [3:0]    kind,
    input  cc_t           cc,
    input  logic [CW-1:0] cnt_in,
    output logic          taken,
    output logic [CW-1:0] cnt_out,
    output logic          cnt_we
);
    logic [CW-1:0] cnt_dec;

    always_comb begin
        cnt_dec = cnt_in - CW'(1);
        taken   = 1'b0;
        cnt_out = cnt_in;
        cnt_we  = 1'b0;
        case (br_kind_e'(kind))
            BK_JMP, BK_JIND: taken = 1'b1;
            BK_JG:   taken = !cc.zro && (cc.sgn == cc.ovf);
            BK_JZ:   taken = cc.zro;
            BK_JS:   taken = cc.sgn;
            BK_LOOP: begin
                cnt_out = cnt_dec;
                cnt_we  = 1'b1;
                taken   = (cnt_dec != '0);
            end
            default: taken = 1'b0;
        endcase
    end

    always_comb begin
        if (cnt_we)
            AST_WE_ONLY_LOOP: assert (kind == 4'd6); // R11
        if (kind == 4'd4)
            AST_JZ_FOLLOWS_ZF: assert (taken == cc.zro); // R7
    end
endmodule

// File: rtl/bl_target_calc.sv
module bl_target_calc #(
    parameter int AW = 32,
    parameter int SW = 8
) (
    input  logic [AW-1:0] next_pc,
    input  logic [AW-1:0] rel_off,
    input  logic          off_wide,
    input  logic          use_ind,
    input  logic [AW-1:0] ind_tgt,
    input  logic          taken,
    output logic [AW-1:0] tgt_addr
);
    localparam int EXT = AW - SW;

    logic [AW-1:0] off_short;
    logic [AW-1:0] off_sel;
    logic [AW-1:0] rel_tgt;

    generate
        if (EXT > 0) begin : g_ext
            assign off_short = {{EXT{rel_off[SW-1]}}, rel_off[SW-1:0]};
        end else begin : g_noext
            assign off_short = rel_off;
        end
    endgenerate

    always_comb begin
        off_sel = off_wide ? rel_off : off_short;
        rel_tgt = next_pc + off_sel;
        if (!taken)       tgt_addr = next_pc;
        else if (use_ind) tgt_addr = ind_tgt;
        else              tgt_addr = rel_tgt;
    end
endmodule

// File: rtl/branch_loop_unit.sv
module branch_loop_unit
    import bl_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 32,
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] next_pc,
    input  logic [3:0]    br_kind,
    input  logic [AW-1:0] rel_off,
    input  logic          off_wide,
    input  logic [AW-1:0] ind_tgt,
    input  logic [CW-1:0] cnt_in,
    input  logic          cmp_en,
    input  logic [CW-1:0] cmp_dst,
    input  logic [CW-1:0] cmp_src,
    input  logic          res_en,
    input  logic [3:0]    res_cc,
    output logic          taken,
    output logic [AW-1:0] tgt_addr,
    output logic [CW-1:0] cnt_out,
    output logic          cnt_we,
    output logic [3:0]    cc
);
    cc_t  cc_q;
    logic use_ind;

    bl_flag_unit #(.DW(CW)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmp_en (cmp_en),
        .cmp_dst(cmp_dst),
        .cmp_src(cmp_src),
        .res_en (res_en),
        .res_cc (cc_t'(res_cc)),
        .cc_q_o (cc_q)
    );

    bl_cond_eval #(.CW(CW)) u_cond (
        .kind   (br_kind),
        .cc     (cc_q),
        .cnt_in (cnt_in),
        .taken  (taken),
        .cnt_out(cnt_out),
        .cnt_we (cnt_we)
    );

    assign use_ind = (br_kind == BK_JIND);

    bl_target_calc #(.AW(AW), .SW(SW)) u_tgt (
        .next_pc (next_pc),
        .rel_off (rel_off),
        .off_wide(off_wide),
        .use_ind (use_ind),
        .ind_tgt (ind_tgt),
        .taken   (taken),
        .tgt_addr(tgt_addr)
    );

    assign cc = cc_q;

    AST_NOT_TAKEN_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        !taken |-> (tgt_addr == next_pc)); // R12
    AST_IND_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (br_kind == 4'd2) |-> (taken && tgt_addr == ind_tgt)); // R4
    AST_LOOP_DECIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (br_kind == 4'd6) |-> (taken == (cnt_in != CW'(1)))); // R11
    AST_LOOP_KEEPS_CC: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_we && !cmp_en && !res_en) |=> $stable(cc)); // R10
endmodule

// File: tb/branch_loop_unit_test.sv
`timescale 1ns/1ps
module branch_loop_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] next_pc = '0, rel_off = '0, ind_tgt = '0, cnt_in = '0;
    logic [31:0] cmp_dst = '0, cmp_src = '0;
    logic [3:0]  br_kind = '0, res_cc = '0;
    logic        off_wide = 1'b0, cmp_en = 1'b0, res_en = 1'b0;
    logic        taken, cnt_we;
    logic [31:0] tgt_addr, cnt_out;
    logic [3:0]  cc;
    int n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    branch_loop_unit uut (
        .clk(clk), .rst_n(rst_n), .next_pc(next_pc), .br_kind(br_kind),
        .rel_off(rel_off), .off_wide(off_wide), .ind_tgt(ind_tgt),
        .cnt_in(cnt_in), .cmp_en(cmp_en), .cmp_dst(cmp_dst), .cmp_src(cmp_src),
        .res_en(res_en), .res_cc(res_cc), .taken(taken), .tgt_addr(tgt_addr),
        .cnt_out(cnt_out), .cnt_we(cnt_we), .cc(cc)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_br(input logic [3:0] k, input logic [31:0] pc,
                          input logic [31:0] off, input logic wide);
        @(negedge clk);
        br_kind = k; next_pc = pc; rel_off = off; off_wide = wide;
        #1;
    endtask

    task automatic do_cmp(input logic [31:0] d, input logic [31:0] s);
        @(negedge clk);
        cmp_dst = d; cmp_src = s; cmp_en = 1'b1;
        @(negedge clk);
        cmp_en = 1'b0;
        #1;
    endtask

    task automatic load_cc(input logic [3:0] f);
        @(negedge clk);
        res_cc = f; res_en = 1'b1;
        @(negedge clk);
        res_en = 1'b0;
        #1;
    endtask

    task automatic t_reset;
        #1;
        chk("R1 reset cc", {28'd0, cc}, 32'd0);
        chk("R12 none not taken", {31'd0, taken}, 32'd0);
    endtask

    task automatic t_relative;
        set_br(4'd1, 32'd1007, 32'h0000_00F9, 1'b0);
        chk("R5 jmp taken", {31'd0, taken}, 32'd1);
        chk("R3 short back", tgt_addr, 32'd1000);
        set_br(4'd1, 32'd1000, 32'hFFFF_FF7F, 1'b0);
        chk("R3 short +127 upper ignored", tgt_addr, 32'd1127);
        set_br(4'd1, 32'd1000, 32'h0000_0080, 1'b0);
        chk("R3 short -128", tgt_addr, 32'd872);
        set_br(4'd1, 32'd1000, 32'h0001_0000, 1'b1);
        chk("R3 wide", tgt_addr, 32'd66536);
    endtask

    task automatic t_indirect;
        ind_tgt = 32'hDEAD_BEE0;
        set_br(4'd2, 32'd500, 32'd4, 1'b0);
        chk("R4 ind taken", {31'd0, taken}, 32'd1);
        chk("R4 ind target", tgt_addr, 32'hDEAD_BEE0);
    endtask

    task automatic t_compare;
        do_cmp(32'd5, 32'd7);
        chk("R8 cmp less", {28'd0, cc}, 32'h5);
        do_cmp(32'h8000_0000, 32'd1);
        chk("R8 cmp ovf", {28'd0, cc}, 32'h8);
        do_cmp(32'd9, 32'd9);
        chk("R8 cmp equal", {28'd0, cc}, 32'h2);
        @(negedge clk);
        #1;
        chk("R10 hold", {28'd0, cc}, 32'h2);
    endtask

    task automatic t_conds;
        load_cc(4'b0000);
        chk("R9 load", {28'd0, cc}, 32'h0);
        set_br(4'd3, 32'd200, 32'h10, 1'b0);
        chk("R6 jg taken", {31'd0, taken}, 32'd1);
        chk("R6 jg tgt", tgt_addr, 32'd216);
        load_cc(4'b1000);
        set_br(4'd3, 32'd200, 32'h10, 1'b0);
        chk("R6 jg sf!=of", {31'd0, taken}, 32'd0);
        chk("R12 seq tgt", tgt_addr, 32'd200);
        load_cc(4'b1010);
        set_br(4'd3, 32'd200, 32'h10, 1'b0);
        chk("R6 jg zf", {31'd0, taken}, 32'd0);
        set_br(4'd4, 32'd200, 32'h10, 1'b0);
        chk("R7 jz set", {31'd0, taken}, 32'd1);
        set_br(4'd5, 32'd200, 32'h10, 1'b0);
        chk("R7 js clear", {31'd0, taken}, 32'd0);
        load_cc(4'b0100);
        set_br(4'd5, 32'd200, 32'h10, 1'b0);
        chk("R7 js set", {31'd0, taken}, 32'd1);
        set_br(4'd4, 32'd200, 32'h10, 1'b0);
        chk("R7 jz clear", {31'd0, taken}, 32'd0);
        @(negedge clk);
        cmp_dst = 32'd3; cmp_src = 32'd3; cmp_en = 1'b1;
        res_cc = 4'b1111; res_en = 1'b1;
        @(negedge clk);
        cmp_en = 1'b0; res_en = 1'b0;
        #1;
        chk("R9 cmp priority", {28'd0, cc}, 32'h2);
    endtask

    task automatic t_loop;
        load_cc(4'b0101);
        cnt_in = 32'd5;
        set_br(4'd6, 32'd1007, 32'h0000_00F9, 1'b0);
        chk("R11 loop cnt", cnt_out, 32'd4);
        chk("R11 loop we", {31'd0, cnt_we}, 32'd1);
        chk("R11 loop taken tgt", tgt_addr, 32'd1000);
        @(negedge clk);
        #1;
        chk("R10 loop keeps cc", {28'd0, cc}, 32'h5);
        cnt_in = 32'd1;
        #1;
        chk("R11 loop exit", {31'd0, taken}, 32'd0);
        chk("R12 loop exit tgt", tgt_addr, 32'd1007);
        cnt_in = 32'd0;
        #1;
        chk("R11 loop wrap", cnt_out, 32'hFFFF_FFFF);
        chk("R11 loop wrap taken", {31'd0, taken}, 32'd1);
        set_br(4'd4, 32'd1007, 32'h0, 1'b0);
        chk("R11 no we", {31'd0, cnt_we}, 32'd0);
        chk("R11 cnt pass", cnt_out, 32'd0);
        set_br(4'd9, 32'd1007, 32'h4, 1'b1);
        chk("R2 unused code", {31'd0, taken}, 32'd0);
        chk("R2 unused tgt", tgt_addr, 32'd1007);
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        t_relative;
        t_indirect;
        t_compare;
        t_conds;
        t_loop;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule